// File: doc/BRIEF.md
# Timer Up-Counter with Coherent Byte Readout

This block is the counting stage of one timer channel. A 16-bit register counts upward by one each time the selected count event arrives. The count event comes from one of three prescaler strobes or from an external event pin. The external pin is synchronized and edge-detected inside the block. Every count event is a single-cycle enable in the system clock domain, so the block uses no derived clocks.

A run control gates counting, and while it is low the count is held at zero. With clear-on-match enabled, a count event that finds the count equal to the compare value loads zero instead of incrementing. With clear-on-match disabled, the counter runs through its whole range. A wrap from all-ones to zero raises a one-cycle overflow interrupt pulse.

Software reads the count over an 8-bit data path. A low-byte read captures the whole count into a snapshot and returns its lower byte. A later high-byte read returns the upper byte of that snapshot, so a carry between the two reads cannot corrupt the value.

Top module: `tmr_upcount`

## Requirements
- R1: After reset, `count_o` is 0, `ovf_irq` is 0 and `rd_data` is 0.
- R2: While `run_en` is low, `count_o` becomes 0 at the next clock edge and stays 0 whatever count events arrive.
- R3: `clk_sel` picks the count event: 0 picks `tick_div1`, 1 picks `tick_div4`, 2 picks `tick_div16`, 3 picks the external input. Each cycle with the selected event high and `run_en` high adds one to the count. Strobes that are not selected have no effect.
- R4: With `clk_sel`=3, a rising level on `ext_evt` adds exactly one count. The new count is visible after the third clock edge that samples `ext_evt` high, and holding `ext_evt` high does not add further counts.
- R5: With `clr_en` high, a count event that finds `count_o` equal to `cmp_val` loads 0 instead of incrementing.
- R6: With `clr_en` low, the count passes `cmp_val` unchanged and runs through its full 16-bit range.
- R7: A count event at 0xFFFF that is not a match-clear wraps the count to 0 and drives `ovf_irq` high for exactly one cycle, in the same cycle the count shows 0.
- R8: A match-clear from 0xFFFF (`clr_en` high, `cmp_val`=0xFFFF) gives count 0 without an overflow pulse.
- R9: A cycle with `rd_lo` high stores the 16-bit count into the snapshot. From the next cycle, `rd_data` shows bits 7:0 of that count.
- R10: A cycle with `rd_hi` high (and `rd_lo` low) makes `rd_data` show bits 15:8 of the snapshot from the next cycle on, even if the counter has moved on. `rd_data` holds its value when neither strobe is high.
- R11: A low-byte read in the same cycle as a count event captures the value before that event.
- R12: When `rd_lo` and `rd_hi` are both high, the low-byte read takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Count enable; low holds the count at zero |
| clr_en | input | 1 | Clear-on-match enable |
| clk_sel | input | 2 | Count event select (0 div1, 1 div4, 2 div16, 3 external) |
| tick_div1 | input | 1 | Prescaler strobe, divide-by-1 tap |
| tick_div4 | input | 1 | Prescaler strobe, divide-by-4 tap |
| tick_div16 | input | 1 | Prescaler strobe, divide-by-16 tap |
| ext_evt | input | 1 | Asynchronous external event input |
| cmp_val | input | 16 | Compare value for clear-on-match |
| rd_lo | input | 1 | Low-byte read strobe, takes a snapshot |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data | output | 8 | Read data byte |
| count_o | output | 16 | Live count value |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
Two pairs of functions can meet in a single cycle. The first pair is match-clear and wraparound. The bench sets the compare value to 0xFFFF with clear-on-match on and counts up to it. It then checks that the count becomes zero and that no overflow pulse appears. The second pair is a snapshot and a count event. The bench issues a low-byte read while the divide-by-1 strobe is counting every cycle. It checks that the byte returned is the count seen before that edge. The high-byte read comes after a carry into the upper byte, and the bench checks that it returns the old upper byte.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    typedef enum logic [1:0] {
        SRC_DIV1  = 2'd0,
        SRC_DIV4  = 2'd1,
        SRC_DIV16 = 2'd2,
        SRC_EXT   = 2'd3
    } tick_src_e;

endpackage

// File: rtl/tcnt_evt_sync.sv
module tcnt_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_async,
    output logic evt_tick
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = evt_async;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_tick = st_q.sync[STAGES-1] & ~st_q.prev;

    // R4: one event per rising level, never two in a row
    assert_ext_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tick |=> !evt_tick);

endmodule

// File: rtl/tcnt_tick_sel.sv
module tcnt_tick_sel
    import tcnt_pkg::*;
(
    input  tick_src_e src,
    input  logic      tick_div1,
    input  logic      tick_div4,
    input  logic      tick_div16,
    input  logic      tick_ext,
    output logic      tick
);
    always_comb begin
        unique case (src)
            SRC_DIV1:  tick = tick_div1;
            SRC_DIV4:  tick = tick_div4;
            SRC_DIV16: tick = tick_div16;
            SRC_EXT:   tick = tick_ext;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcnt_core.sv
module tcnt_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             clr_en,
    input  logic             tick,
    input  logic [WIDTH-1:0] cmp_val,
    output logic [WIDTH-1:0] cnt,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             ovf;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     hit;

    assign hit = clr_en && (st_q.cnt == cmp_val);

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (!run_en) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (hit) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.ovf = (st_q.cnt == CNT_MAX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    assert_stop_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt == '0));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !tick) |=> $stable(cnt));

    assert_match_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && clr_en && cnt == cmp_val) |=> (cnt == '0));

    assert_ovf_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (cnt == '0 && $past(cnt) == CNT_MAX));

    assert_no_ovf_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && clr_en && cnt == cmp_val) |=> !ovf);

endmodule

// File: rtl/tcnt_rd_latch.sv
module tcnt_rd_latch #(
    parameter int WIDTH  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [WIDTH-1:0]  cnt,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int HI_LSB = WIDTH - BYTE_W;

    typedef struct packed {
        logic [WIDTH-1:0]  snap;
        logic [BYTE_W-1:0] rdata;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_lo) begin
            st_d.snap  = cnt;
            st_d.rdata = cnt[BYTE_W-1:0];
        end else if (rd_hi) begin
            st_d.rdata = st_q.snap[HI_LSB +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;

    // R9 / R11: low read returns the pre-edge count byte
    assert_lo_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (rd_data == $past(cnt[BYTE_W-1:0])));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lo && !rd_hi) |=> $stable(rd_data));

endmodule

// File: rtl/tmr_upcount.sv
module tmr_upcount
    import tcnt_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              clr_en,
    input  logic [1:0]        clk_sel,
    input  logic              tick_div1,
    input  logic              tick_div4,
    input  logic              tick_div16,
    input  logic              ext_evt,
    input  logic [WIDTH-1:0]  cmp_val,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_data,
    output logic [WIDTH-1:0]  count_o,
    output logic              ovf_irq
);
    logic ext_tick;
    logic tick;

    tcnt_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_async (ext_evt),
        .evt_tick  (ext_tick)
    );

    tcnt_tick_sel u_sel (
        .src        (tick_src_e'(clk_sel)),
        .tick_div1  (tick_div1),
        .tick_div4  (tick_div4),
        .tick_div16 (tick_div16),
        .tick_ext   (ext_tick),
        .tick       (tick)
    );

    tcnt_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .clr_en  (clr_en),
        .tick    (tick),
        .cmp_val (cmp_val),
        .cnt     (count_o),
        .ovf     (ovf_irq)
    );

    tcnt_rd_latch #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi),
        .cnt     (count_o),
        .rd_data (rd_data)
    );

    // R3: an unselected strobe never moves the count
    assert_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && clk_sel == 2'd1 && !tick_div4) |=> $stable(count_o));

endmodule

// File: tb/tb_tmr_upcount.sv
module tb_tmr_upcount;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, clr_en = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic        tick_div1 = 1'b0, tick_div4 = 1'b0, tick_div16 = 1'b0;
    logic        ext_evt = 1'b0;
    logic [15:0] cmp_val = 16'h0;
    logic        rd_lo = 1'b0, rd_hi = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] count_o;
    logic        ovf_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_upcount dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr_en(clr_en),
        .clk_sel(clk_sel), .tick_div1(tick_div1), .tick_div4(tick_div4),
        .tick_div16(tick_div16), .ext_evt(ext_evt), .cmp_val(cmp_val),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data),
        .count_o(count_o), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic restart();
        tick_div1 = 1'b0; tick_div4 = 1'b0; tick_div16 = 1'b0;
        run_en = 1'b0;
        edges(1);
        run_en = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        edges(3);
        chk("R1 count", count_o, 0);
        chk("R1 ovf", ovf_irq, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        edges(1);
    endtask

    task automatic t_div1_and_stop();
        clk_sel = 2'd0; clr_en = 1'b0;
        restart();
        tick_div1 = 1'b1;
        edges(10);
        chk("R3 div1 count", count_o, 10);
        run_en = 1'b0;
        edges(1);
        chk("R2 stop clears", count_o, 0);
        edges(3);
        chk("R2 stays zero", count_o, 0);
    endtask

    task automatic t_select();
        clk_sel = 2'd1;
        restart();
        tick_div1 = 1'b1; tick_div16 = 1'b1;
        for (int k = 0; k < 5; k++) begin
            tick_div4 = 1'b1; edges(1);
            tick_div4 = 1'b0; edges(3);
        end
        chk("R3 div4 only", count_o, 5);
        clk_sel = 2'd2;
        restart();
        tick_div1 = 1'b1; tick_div4 = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick_div16 = 1'b1; edges(1);
            tick_div16 = 1'b0; edges(2);
        end
        chk("R3 div16 only", count_o, 3);
    endtask

    task automatic t_ext();
        clk_sel = 2'd3;
        restart();
        tick_div1 = 1'b1; tick_div4 = 1'b1; tick_div16 = 1'b1;
        ext_evt = 1'b1;
        edges(2);
        chk("R4 ext latency", count_o, 0);
        edges(1);
        chk("R4 ext first edge", count_o, 1);
        edges(5);
        chk("R4 ext held high", count_o, 1);
        ext_evt = 1'b0;
        edges(3);
        ext_evt = 1'b1;
        edges(4);
        chk("R4 ext second edge", count_o, 2);
        ext_evt = 1'b0;
    endtask

    task automatic t_match_clear();
        clk_sel = 2'd0; clr_en = 1'b1; cmp_val = 16'd5;
        restart();
        tick_div1 = 1'b1;
        edges(5);
        chk("R5 at compare", count_o, 5);
        edges(1);
        chk("R5 cleared", count_o, 0);
        chk("R5 no ovf", ovf_irq, 0);
        edges(1);
        chk("R5 counts on", count_o, 1);
        clr_en = 1'b0;
        restart();
        tick_div1 = 1'b1;
        edges(8);
        chk("R6 free run past compare", count_o, 8);
    endtask

    task automatic t_read();
        clk_sel = 2'd0; clr_en = 1'b0;
        restart();
        tick_div1 = 1'b1;
        edges(253);
        chk("R9 setup", count_o, 16'h00FD);
        rd_lo = 1'b1;
        edges(1);
        rd_lo = 1'b0;
        chk("R11 lo byte pre-edge", rd_data, 8'hFD);
        chk("R11 counter moved", count_o, 16'h00FE);
        edges(5);
        chk("R10 carry happened", count_o, 16'h0103);
        rd_hi = 1'b1;
        edges(1);
        rd_hi = 1'b0;
        chk("R10 hi from snapshot", rd_data, 8'h00);
        edges(2);
        chk("R10 hold", rd_data, 8'h00);
        rd_lo = 1'b1; rd_hi = 1'b1;
        edges(1);
        rd_lo = 1'b0; rd_hi = 1'b0;
        chk("R12 lo wins", rd_data, 8'h06);
        rd_hi = 1'b1;
        edges(1);
        rd_hi = 1'b0;
        chk("R9 snapshot taken", rd_data, 8'h01);
    endtask

    task automatic t_wrap();
        clk_sel = 2'd0; clr_en = 1'b0;
        restart();
        tick_div1 = 1'b1;
        edges(65535);
        chk("R6 full range", count_o, 16'hFFFF);
        chk("R7 no early ovf", ovf_irq, 0);
        edges(1);
        chk("R7 wrap count", count_o, 0);
        chk("R7 ovf pulse", ovf_irq, 1);
        edges(1);
        chk("R7 ovf one cycle", ovf_irq, 0);
        chk("R7 counts after wrap", count_o, 1);
    endtask

    task automatic t_clear_at_top();
        clk_sel = 2'd0; clr_en = 1'b1; cmp_val = 16'hFFFF;
        restart();
        tick_div1 = 1'b1;
        edges(65535);
        chk("R8 at top", count_o, 16'hFFFF);
        edges(1);
        chk("R8 cleared", count_o, 0);
        chk("R8 no ovf", ovf_irq, 0);
    endtask

    initial begin
        t_reset();
        t_div1_and_stop();
        t_select();
        t_ext();
        t_match_clear();
        t_read();
        t_wrap();
        t_clear_at_top();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 180000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule